// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one unsigned integer by another over several clock cycles and produces both the quotient and the remainder. A single-cycle start request, taken only while the block is idle, captures both operands. The block then performs one iteration per clock: it shifts the partial remainder left, tries subtracting the divisor, and either keeps the difference or adds the divisor back. Each trial yields one quotient bit.

The working register is twice the operand width. Its upper half holds the partial remainder and its lower half holds the dividend bits that have not yet been used. The divisor is held in its own register and does not move. The quotient is built in a separate register, one bit per iteration. After exactly as many iterations as the operand width, the block drops busy and raises done. The results then stay on the outputs until the next start. A zero divisor raises a flag and needs no special path, because the arithmetic itself gives an all-ones quotient and returns the dividend as the remainder.

Top module: `restoring_divider`

## Requirements
- R1: While reset is active, and after it is released with no start, busy, done and div_by_zero are 0 and quotient and remainder are 0.
- R2: When start is high at a clock edge while busy is low, the operands are captured, and after that edge busy is 1 and done is 0.
- R3: busy stays high for exactly WIDTH clock cycles after the capturing edge. At the edge that ends the last iteration, busy falls and done rises.
- R4: For a nonzero divisor, quotient equals the integer part of dividend divided by divisor once done is 1.
- R5: For a nonzero divisor, remainder equals dividend modulo divisor once done is 1, and is therefore smaller than the divisor.
- R6: For a zero divisor, div_by_zero is 1 once done is 1, quotient is all ones (15 for WIDTH 4), and remainder equals the dividend.
- R7: A start pulse that arrives while busy is 1 is ignored. The running operation keeps its operands and completes with the result of the originally captured values.
- R8: Once done is 1, done, quotient, remainder and div_by_zero keep their values until the next accepted start, whatever the operand inputs do.
- R9: busy and done are never 1 in the same cycle.
- R10: An accepted start with a nonzero divisor clears div_by_zero that was left set by an earlier division by zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| start | input | 1 | Request to begin a division; sampled only while idle |
| dividend | input | WIDTH | Unsigned dividend, captured at an accepted start |
| divisor | input | WIDTH | Unsigned divisor, captured at an accepted start |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | High from completion until the next accepted start |
| div_by_zero | output | 1 | High when the captured divisor was zero |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |

## Verification
Every iteration writes one quotient bit and rewrites the partial remainder that every later trial depends on. A wrong borrow decision or a lost shifted-out bit therefore shows up at completion as a wrong quotient or a remainder no smaller than the divisor. It appears exactly WIDTH+1 edges after start, and only for the operand pairs that reach the faulty case. For that reason every dividend and divisor pair is exercised. A wrong iteration count or control state shows up on the edge it occurs as busy and done at the wrong cycle, or both high together. It is caught by checking busy and done on every cycle of every operation.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rdiv_state_e;

endpackage

// File: rtl/rdiv_trial.sv
// One trial step: subtract the divisor from the shifted partial remainder,
// test the borrow, and add the divisor back if the difference went negative.
module rdiv_trial #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH:0]   partial,
  input  logic [WIDTH-1:0] dsr,
  output logic [WIDTH-1:0] new_left,
  output logic             qbit
);

  localparam int EW = WIDTH + 2;

  logic [EW-1:0] diff;
  logic [EW-1:0] restored;
  logic          neg;

  always_comb begin
    diff     = {1'b0, partial} - {2'b00, dsr};
    neg      = diff[EW-1];
    restored = diff + {2'b00, dsr};
    new_left = neg ? restored[WIDTH-1:0] : diff[WIDTH-1:0];
    qbit     = ~neg;
  end

endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

  rdiv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q, done_d;
  logic          last;

  always_comb begin
    load    = (state_q == ST_IDLE) && start;
    step    = (state_q == ST_RUN);
    last    = step && (cnt_q == LAST_CNT);
    state_d = state_q;
    if (load)      state_d = ST_RUN;
    else if (last) state_d = ST_IDLE;
    cnt_en = load | step;
    cnt_d  = load ? '0 : cnt_q + 1'b1;
    done_d = done_q;
    if (load)      done_d = 1'b0;
    else if (last) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;

  a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  a_r3_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != LAST_CNT) |=> busy);

  a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);

  localparam int RW = 2 * WIDTH;

  logic [RW-1:0]    rem_q, rem_d;
  logic [WIDTH-1:0] quo_q, quo_d;
  logic [WIDTH-1:0] dsr_q;
  logic             dbz_q;
  logic             rem_en;
  logic [WIDTH:0]   partial;
  logic [WIDTH-1:0] low_shift;
  logic [WIDTH-1:0] new_left;
  logic             qbit;

  // Shifted partial remainder keeps the bit that leaves the upper half.
  assign partial   = rem_q[RW-1:WIDTH-1];
  assign low_shift = {rem_q[WIDTH-2:0], 1'b0};

  rdiv_trial #(.WIDTH(WIDTH)) u_trial (
    .partial  (partial),
    .dsr      (dsr_q),
    .new_left (new_left),
    .qbit     (qbit)
  );

  always_comb begin
    rem_en = load | step;
    if (load) begin
      rem_d = {{WIDTH{1'b0}}, dividend};
      quo_d = '0;
    end else begin
      rem_d = {new_left, low_shift};
      quo_d = {quo_q[WIDTH-2:0], qbit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      dbz_q <= 1'b0;
    end else begin
      if (rem_en) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
      end
      if (load) begin
        dsr_q <= divisor;
        dbz_q <= (divisor == '0);
      end
    end
  end

  assign quotient    = quo_q;
  assign remainder   = rem_q[RW-1:WIDTH];
  assign div_by_zero = dbz_q;

  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dsr_q != '0) |=> (rem_q[RW-1:WIDTH] < dsr_q));

  a_r6_zero_divisor_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dsr_q == '0) |=> quo_q[0]);

  a_r7_divisor_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dsr_q));

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_by_zero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  logic load;
  logic step;

  rdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  rdiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .step        (step),
    .dividend    (dividend),
    .divisor     (divisor),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
  );

  a_r10_flag_matches_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_by_zero) |=> !div_by_zero);

endmodule

// File: tb/restoring_divider_test.sv
module restoring_divider_test;

  localparam int W          = 4;
  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] dividend;
  logic [W-1:0] divisor;
  logic         busy;
  logic         done;
  logic         div_by_zero;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  int  checks;
  int  errors;
  bit  finished;

  restoring_divider #(.WIDTH(W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .div_by_zero (div_by_zero),
    .quotient    (quotient),
    .remainder   (remainder)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int b, input bit poke);
    int exp_q;
    int exp_r;
    exp_q = (b == 0) ? (1 << W) - 1 : a / b;
    exp_r = (b == 0) ? a : a % b;
    start    = 1'b1;
    dividend = W'(a);
    divisor  = W'(b);
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2", {busy, done}, 2);
    for (int i = 1; i < W; i++) begin
      if (poke && i == 1) begin
        start    = 1'b1;
        dividend = ~W'(a);
        divisor  = W'(b + 1);
      end
      @(negedge clk);
      start = 1'b0;
      chk(busy && !done, "R3", {busy, done}, 2);
      chk(!(busy && done), "R9", {busy, done}, 2);
    end
    @(negedge clk);
    chk(done && !busy, "R3", {busy, done}, 1);
    if (poke) begin
      chk(quotient == W'(exp_q), "R7", quotient, exp_q);
      chk(remainder == W'(exp_r), "R7", remainder, exp_r);
    end else begin
      chk(quotient == W'(exp_q), (b == 0) ? "R6" : "R4", quotient, exp_q);
      chk(remainder == W'(exp_r), (b == 0) ? "R6" : "R5", remainder, exp_r);
    end
    chk(div_by_zero == (b == 0), (b == 0) ? "R6" : "R10", div_by_zero, (b == 0));
    dividend = W'(a + 7);
    divisor  = W'(b + 3);
    repeat (2) @(negedge clk);
    chk(done && !busy, "R8", {busy, done}, 1);
    chk(quotient == W'(exp_q) && remainder == W'(exp_r), "R8",
        {quotient, remainder}, {W'(exp_q), W'(exp_r)});
    chk(div_by_zero == (b == 0), "R8", div_by_zero, (b == 0));
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    start    = 1'b0;
    dividend = '0;
    divisor  = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !div_by_zero && quotient == 0 && remainder == 0, "R1",
        {busy, done, div_by_zero, quotient, remainder}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !div_by_zero && quotient == 0 && remainder == 0, "R1",
        {busy, done, div_by_zero, quotient, remainder}, 0);
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_op(a, b, ((a + b) % 5) == 0);
      end
    end
    // R10: zero divisor followed at once by a nonzero one
    run_op(9, 0, 1'b0);
    run_op(9, 4, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule